// File: doc/BRIEF.md
# Persistent Request Ordering Arbiter

This block sits at a home memory node and gives starving processors a guaranteed escape path. A processor that has failed to gather the permissions it needs for a block sends the arbiter a persistent request naming itself and the block address. The arbiter queues these requests in arrival order and lets exactly one of them be in force at any time. It announces the chosen request to every node by broadcasting an activate message. Each node keeps its own table of in-force requests and updates it from these broadcasts.

The activated request stays in force until its owner is satisfied and sends a release. The arbiter then broadcasts a deactivate for the finished request. After that it broadcasts the activate for the next queued request, if one is waiting. Broadcasts leave through a valid/ready port, and each message is held until it is accepted. Requests and releases share one input port that is always accepted. Misuse of that port is dropped and reported on a one-cycle error output.

Top module: `pr_order_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bc_valid` and `err` are 0.
- R2: Accepted requests are activated in the order they arrived (first come, first served). The queue holds up to NUM_PROC entries, with at most one entry per processor.
- R3: An activate broadcast has `bc_kind` = 0 and carries the requester's ID on `bc_proc` and its block address on `bc_addr`.
- R4: At most one request is in force at a time. No activate is broadcast while a request is in force. A correct release makes the arbiter broadcast a deactivate (`bc_kind` = 1) with the released request's ID and address, and only after that deactivate does it broadcast the next activate.
- R5: While `bc_valid` is 1 and `bc_ready` is 0, the broadcast message (`bc_kind`, `bc_proc`, `bc_addr`) stays unchanged and `bc_valid` stays 1.
- R6: A request (`in_kind` = 0) from a processor that already has a queued or in-force request is ignored. `err` is 1 in the cycle after it.
- R7: A release (`in_kind` = 1) is ignored, and `err` is 1 in the cycle after it, if it comes from a processor other than the in-force requester, or if no activate is outstanding.
- R8: Once a release is accepted, the releasing processor may request again at once, and that request joins the back of the queue.
- R9: A request that arrives in the same cycle as the handshake of a deactivate broadcast is kept, and it is activated even when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message present this cycle |
| in_kind | input | 1 | 0 = persistent request, 1 = release |
| in_proc | input | ID_W | Sending processor ID |
| in_addr | input | ADDR_W | Block address (used for requests) |
| bc_valid | output | 1 | Broadcast message present |
| bc_ready | input | 1 | Broadcast message accepted this cycle |
| bc_kind | output | 1 | 0 = activate, 1 = deactivate |
| bc_proc | output | ID_W | Requester ID of the broadcast request |
| bc_addr | output | ADDR_W | Block address of the broadcast request |
| err | output | 1 | One-cycle pulse after an ignored input |

## Verification
Two functions can fall in the same cycle: a new request being queued, and the queue being popped when a deactivate handshake ends. The bench provokes this by raising `bc_ready` for the deactivate in the same cycle that it drives a fresh request while the queue is empty. It then requires an activate for that request, with the right ID and address, to follow. A second collision is a release and a queued re-request from the releasing processor. The bench judges this by the arrival order of the later activates.

// File: rtl/pr_arb_pkg.sv
package pr_arb_pkg;

  typedef enum logic {
    IN_REQUEST = 1'b0,
    IN_RELEASE = 1'b1
  } in_kind_e;

  typedef enum logic {
    BC_ACTIVATE   = 1'b0,
    BC_DEACTIVATE = 1'b1
  } bc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_SEND_ACT   = 2'd1,
    ST_HOLD       = 2'd2,
    ST_SEND_DEACT = 2'd3
  } arb_state_e;

endpackage

// File: rtl/pr_req_fifo.sv
module pr_req_fifo #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_proc,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic              empty,
  output logic              full,
  output logic [ID_W-1:0]   head_proc,
  output logic [ADDR_W-1:0] head_addr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]   proc_mem [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // One write-enabled slot per entry; payload needs no reset.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        proc_mem[e] <= push_proc;
        addr_mem[e] <= push_addr;
      end
    end
  end

  assign head_proc = proc_mem[rd_ptr_q];
  assign head_addr = addr_mem[rd_ptr_q];

endmodule

// File: rtl/pr_busy_tracker.sv
module pr_busy_tracker #(
  parameter int NUM_PROC = 4,
  parameter int ID_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [ID_W-1:0] set_id,
  input  logic            clr,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] query_id,
  output logic            busy_o
);

  logic [NUM_PROC-1:0] busy_q;

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_bit
    logic hit_set, hit_clr, bit_d;
    assign hit_set = set && (set_id == ID_W'(p));
    assign hit_clr = clr && (clr_id == ID_W'(p));
    always_comb begin
      bit_d = busy_q[p];
      if (hit_clr) bit_d = 1'b0;
      if (hit_set) bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q[p] <= 1'b0;
      else        busy_q[p] <= bit_d;
    end
  end

  // IDs beyond the processor count read as busy so they are rejected.
  always_comb begin
    if (int'(query_id) < NUM_PROC) busy_o = busy_q[query_id];
    else                           busy_o = 1'b1;
  end

endmodule

// File: rtl/pr_bcast_ctrl.sv
module pr_bcast_ctrl
  import pr_arb_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [ID_W-1:0]   q_proc,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_pop,
  input  logic              rel_ok,
  output logic              holding,
  output logic [ID_W-1:0]   cur_proc,
  output logic              bc_valid,
  input  logic              bc_ready,
  output logic              bc_kind,
  output logic [ID_W-1:0]   bc_proc,
  output logic [ADDR_W-1:0] bc_addr
);

  arb_state_e        state_q, state_d;
  logic [ID_W-1:0]   proc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_en;

  always_comb begin
    state_d = state_q;
    q_pop   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!q_empty) begin
          q_pop   = 1'b1;
          state_d = ST_SEND_ACT;
        end
      end
      ST_SEND_ACT: begin
        if (bc_ready) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (rel_ok) state_d = ST_SEND_DEACT;
      end
      ST_SEND_DEACT: begin
        if (bc_ready) begin
          if (!q_empty) begin
            q_pop   = 1'b1;
            state_d = ST_SEND_ACT;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_en = q_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proc_q <= '0;
      addr_q <= '0;
    end else if (load_en) begin
      proc_q <= q_proc;
      addr_q <= q_addr;
    end
  end

  assign holding  = (state_q == ST_HOLD);
  assign cur_proc = proc_q;
  assign bc_valid = (state_q == ST_SEND_ACT) || (state_q == ST_SEND_DEACT);
  assign bc_kind  = (state_q == ST_SEND_DEACT) ? BC_DEACTIVATE : BC_ACTIVATE;
  assign bc_proc  = proc_q;
  assign bc_addr  = addr_q;

endmodule

// File: rtl/pr_order_arbiter.sv
module pr_order_arbiter
  import pr_arb_pkg::*;
#(
  parameter  int NUM_PROC = 4,
  parameter  int ADDR_W   = 16,
  localparam int ID_W     = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [ID_W-1:0]   in_proc,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              bc_valid,
  input  logic              bc_ready,
  output logic              bc_kind,
  output logic [ID_W-1:0]   bc_proc,
  output logic [ADDR_W-1:0] bc_addr,
  output logic              err
);

  logic            is_req, is_rel, dup_req, bad_rel, rel_ok, push;
  logic            busy_hit, holding, q_empty, q_full, q_pop;
  logic [ID_W-1:0] q_proc, cur_proc;
  logic [ADDR_W-1:0] q_addr;
  logic            err_d, err_q;

  assign is_req  = in_valid && (in_kind == IN_REQUEST);
  assign is_rel  = in_valid && (in_kind == IN_RELEASE);
  assign dup_req = is_req && busy_hit;
  assign push    = is_req && !busy_hit;
  assign rel_ok  = is_rel && holding && (in_proc == cur_proc);
  assign bad_rel = is_rel && !rel_ok;
  assign err_d   = dup_req || bad_rel;

  pr_busy_tracker #(.NUM_PROC(NUM_PROC), .ID_W(ID_W)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set(push), .set_id(in_proc),
    .clr(rel_ok), .clr_id(in_proc),
    .query_id(in_proc), .busy_o(busy_hit)
  );

  pr_req_fifo #(.DEPTH(NUM_PROC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_proc(in_proc), .push_addr(in_addr),
    .pop(q_pop), .empty(q_empty), .full(q_full),
    .head_proc(q_proc), .head_addr(q_addr)
  );

  pr_bcast_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .q_empty(q_empty), .q_proc(q_proc), .q_addr(q_addr), .q_pop(q_pop),
    .rel_ok(rel_ok), .holding(holding), .cur_proc(cur_proc),
    .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_kind(bc_kind),
    .bc_proc(bc_proc), .bc_addr(bc_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

endmodule

// File: rtl/pr_order_arbiter_chk.sv
module pr_order_arbiter_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              bc_valid,
  input logic              bc_ready,
  input logic              bc_kind,
  input logic [ID_W-1:0]   bc_proc,
  input logic [ADDR_W-1:0] bc_addr,
  input logic              err,
  input logic              push,
  input logic              q_full
);

  logic            open_q;
  logic [ID_W-1:0] open_proc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      open_proc_q <= '0;
    end else if (bc_valid && bc_ready) begin
      open_q      <= !bc_kind;
      open_proc_q <= bc_proc;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!bc_valid && !err)
        else $error("broadcast or error active during reset");
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !q_full);

  assert_single_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_ready && !bc_kind) |-> !open_q);

  assert_deact_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_ready && bc_kind) |-> (open_q && bc_proc == open_proc_q));

  assert_hold_message_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !bc_ready) |=> (bc_valid && $stable(bc_kind)
                                 && $stable(bc_proc) && $stable(bc_addr)));

  assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid));

endmodule

bind pr_order_arbiter pr_order_arbiter_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_kind(bc_kind),
  .bc_proc(bc_proc), .bc_addr(bc_addr), .err(err),
  .push(push), .q_full(q_full)
);

// File: tb/pr_order_arbiter_tb.sv
module pr_order_arbiter_tb;

  localparam int NUM_PROC = 4;
  localparam int ADDR_W   = 16;
  localparam int ID_W     = 2;

  // Vector fields: [31:28] op, [27:24] proc, [23:8] addr, [0] expected err.
  // op 0 = request, 1 = release, 2 = expect activate, 3 = expect deactivate.
  localparam int NVEC = 18;
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0, 4'd1, 16'h00A1, 8'd0},
    {4'd0, 4'd2, 16'h00B2, 8'd0},
    {4'd0, 4'd1, 16'h0FFF, 8'd1},
    {4'd2, 4'd1, 16'h00A1, 8'd0},
    {4'd1, 4'd2, 16'h0000, 8'd1},
    {4'd0, 4'd3, 16'h00C3, 8'd0},
    {4'd1, 4'd1, 16'h0000, 8'd0},
    {4'd3, 4'd1, 16'h00A1, 8'd0},
    {4'd2, 4'd2, 16'h00B2, 8'd0},
    {4'd0, 4'd1, 16'h00D4, 8'd0},
    {4'd1, 4'd2, 16'h0000, 8'd0},
    {4'd3, 4'd2, 16'h00B2, 8'd0},
    {4'd2, 4'd3, 16'h00C3, 8'd0},
    {4'd1, 4'd3, 16'h0000, 8'd0},
    {4'd3, 4'd3, 16'h00C3, 8'd0},
    {4'd2, 4'd1, 16'h00D4, 8'd0},
    {4'd1, 4'd1, 16'h0000, 8'd0},
    {4'd3, 4'd1, 16'h00D4, 8'd0}
  };

  logic              clk, rst_n;
  logic              in_valid, in_kind;
  logic [ID_W-1:0]   in_proc;
  logic [ADDR_W-1:0] in_addr;
  logic              bc_valid, bc_ready, bc_kind, err;
  logic [ID_W-1:0]   bc_proc;
  logic [ADDR_W-1:0] bc_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pr_order_arbiter #(.NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_kind(in_kind), .in_proc(in_proc), .in_addr(in_addr),
    .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_kind(bc_kind),
    .bc_proc(bc_proc), .bc_addr(bc_addr), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one input message for one cycle, then check the error pulse.
  task automatic send(input bit kind, input int proc, input int addr,
                      input bit exp_err, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_kind  = kind;
    in_proc  = ID_W'(proc);
    in_addr  = ADDR_W'(addr);
    @(negedge clk);
    in_valid = 1'b0;
    check(err == exp_err, req, int'(err), int'(exp_err));
  endtask

  // Wait for a broadcast, check its contents, accept it.
  task automatic take(input bit kind, input int proc, input int addr, input string req);
    int wait_n = 0;
    while (!bc_valid && wait_n < 50) begin
      @(negedge clk);
      wait_n++;
    end
    check(bc_valid == 1'b1, req, int'(bc_valid), 1);
    check(bc_kind == kind, req, int'(bc_kind), int'(kind));
    check(int'(bc_proc) == proc, req, int'(bc_proc), proc);
    check(int'(bc_addr) == addr, req, int'(bc_addr), addr);
    bc_ready = 1'b1;
    @(negedge clk);
    bc_ready = 1'b0;
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_kind  = 1'b0;
    in_proc  = '0;
    in_addr  = '0;
    bc_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!bc_valid, "R1 bc_valid in reset", int'(bc_valid), 0);
    check(!err, "R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bc_valid && !err, "R1 after release", int'({bc_valid, err}), 0);

    // Table walk: ordering R2, fields R3, handshake R4, errors R6/R7, re-request R8.
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      int p, a;
      bit e;
      op = VEC[i][31:28];
      p  = int'(VEC[i][27:24]);
      a  = int'(VEC[i][23:8]);
      e  = VEC[i][0];
      case (op)
        4'd0: send(1'b0, p, a, e, e ? "R6 duplicate request" : "R8 request accepted");
        4'd1: send(1'b1, p, 0, e, e ? "R7 wrong releaser" : "R4 release accepted");
        4'd2: take(1'b0, p, a, "R2 R3 activate order/fields");
        default: take(1'b1, p, a, "R4 deactivate fields");
      endcase
    end

    // R7: release with nothing in force
    repeat (2) @(negedge clk);
    check(!bc_valid, "R4 idle after drain", int'(bc_valid), 0);
    send(1'b1, 0, 0, 1'b1, "R7 release while idle");

    // R5: hold under backpressure; R4: no second activate while one is in force
    send(1'b0, 0, 16'h1110, 1'b0, "R2 fill p0");
    send(1'b0, 3, 16'h3330, 1'b0, "R2 fill p3");
    send(1'b0, 2, 16'h2220, 1'b0, "R2 fill p2");
    send(1'b0, 1, 16'h1111, 1'b0, "R2 fill p1");
    repeat (4) @(negedge clk);
    check(bc_valid && bc_proc == 2'd0 && bc_addr == 16'h1110,
          "R5 held under backpressure", int'(bc_addr), 16'h1110);
    take(1'b0, 0, 16'h1110, "R2 first of full queue");
    repeat (5) @(negedge clk);
    check(!bc_valid, "R4 no activate while one in force", int'(bc_valid), 0);
    send(1'b1, 0, 0, 1'b0, "R4 release p0");
    take(1'b1, 0, 16'h1110, "R4 deactivate p0");
    take(1'b0, 3, 16'h3330, "R2 second in order");
    send(1'b1, 3, 0, 1'b0, "R4 release p3");
    take(1'b1, 3, 16'h3330, "R4 deactivate p3");
    take(1'b0, 2, 16'h2220, "R2 third in order");
    send(1'b1, 2, 0, 1'b0, "R4 release p2");
    take(1'b1, 2, 16'h2220, "R4 deactivate p2");
    take(1'b0, 1, 16'h1111, "R2 fourth in order");
    send(1'b1, 1, 0, 1'b0, "R4 release p1");

    // R9: request lands in the deactivate handshake cycle with an empty queue
    while (!bc_valid) @(negedge clk);
    check(bc_kind == 1'b1, "R9 deactivate pending", int'(bc_kind), 1);
    bc_ready = 1'b1;
    in_valid = 1'b1;
    in_kind  = 1'b0;
    in_proc  = 2'd2;
    in_addr  = 16'h0909;
    @(negedge clk);
    bc_ready = 1'b0;
    in_valid = 1'b0;
    check(!err, "R9 no error on collision", int'(err), 0);
    take(1'b0, 2, 16'h0909, "R9 request kept");
    send(1'b1, 2, 0, 1'b0, "R9 release");
    take(1'b1, 2, 16'h0909, "R9 deactivate");

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule